// File: doc/BRIEF.md
# Hardwired Control Step Sequencer

This block produces the register-transfer control strobes for a tiny processor that knows exactly three instructions. It has no microcode store. A five-position one-hot step ring walks through steps T1 to T5, and every strobe is a sum of products of the current step and the held instruction. When the sequence ends the ring goes back to T1. From there it either waits for the next start request or begins the next instruction at once.

A start request is a strobe (`go_i`) together with a one-hot instruction code (`instr_i`: bit 0 selects I1, bit 1 selects I2, bit 2 selects I3). The code is captured when the sequence begins and is held for all five steps, so the upstream decoder may change `instr_i` freely in the meantime. A strobe that every instruction raises in the same step is decoded from the step alone. This holds for Z drive and A load in T3, and for the end marker in T5.

Top module: `step_ctrl_unit`

## Requirements
- R1: After reset the step output is 5'b00001 (T1), every control strobe is low, and the block stays idle until a start is accepted.
- R2: While idle, `go_i` high with a one-hot `instr_i` at a clock edge starts a sequence: from that edge on, the step output is T1 and the strobes for T1 of the captured instruction are driven.
- R3: While running, the step output has exactly one bit set and moves one position up (T1 to T2 to T3 to T4 to T5) on each clock edge.
- R4: `seq_end` is high only in T5. On the edge after T5 the step returns to T1, and with no new start all strobes go low.
- R5: A start request whose `instr_i` is not one-hot (zero bits, or two or more bits set) is ignored: the block stays idle, with step T1 and all strobes low.
- R6: During T1 to T4, `go_i` and `instr_i` have no effect. The running instruction finishes its schedule unchanged.
- R7: I1 drives, in T1: a_load, b_drive, c_load; in T2: pc_drive, b_load; in T3: z_drive, a_load; in T4: b_load, c_drive; in T5: seq_end only.
- R8: I2 drives, in T1: c_load, b_drive, d_load; in T2: a_drive, b_load; in T3: z_drive, a_load; in T4: b_load, c_drive; in T5: seq_end only.
- R9: I3 drives, in T1: d_load, a_drive; in T2: a_load, b_drive; in T3: z_drive, a_load; in T4: d_drive, a_load; in T5: seq_end only.
- R10: a_load equals T1·I1 + T2·I3 + T4·I3 + T3, and z_drive is high in T3 for every instruction. No other strobe is high in any step beyond those listed in R7 to R9.
- R11: A valid start presented during T5 begins the next instruction at T1 on the very next edge, with no idle cycle between the two instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request |
| instr_i | input | 3 | One-hot instruction code (bit0 I1, bit1 I2, bit2 I3) |
| step_o | output | 5 | One-hot step, bit0 = T1 ... bit4 = T5 |
| a_load | output | 1 | Load register A |
| a_drive | output | 1 | Drive register A onto the bus |
| b_load | output | 1 | Load register B |
| b_drive | output | 1 | Drive register B onto the bus |
| c_load | output | 1 | Load register C |
| c_drive | output | 1 | Drive register C onto the bus |
| d_load | output | 1 | Load register D |
| d_drive | output | 1 | Drive register D onto the bus |
| pc_drive | output | 1 | Drive the program counter onto the bus |
| z_drive | output | 1 | Drive the ALU result register onto the bus |
| seq_end | output | 1 | Last step of the instruction |

## Verification
A start accepted at a rising edge shows up one edge later. The step output is T1 and the T1 strobes are valid from that edge, because the strobes are decoded combinationally from registered state. Each later step arrives exactly one edge after the one before it.

The bench changes inputs on the falling edge and reads every output on the next falling edge. Each read therefore covers exactly one step, and all eleven strobes are compared as one vector against a table built from the schedules. Ignored starts and back-to-back starts are presented at a falling edge and judged at the following falling edge, which is the first point where an accepted start could be seen.

// File: rtl/step_ctrl_pkg.sv
package step_ctrl_pkg;

    localparam int unsigned N_STEPS = 5;
    localparam int unsigned N_INSTR = 3;

    localparam logic [N_STEPS-1:0] STEP_FIRST = N_STEPS'(1);

    typedef struct packed {
        logic               busy;
        logic [N_STEPS-1:0] step;
        logic [N_INSTR-1:0] instr;
    } seq_st_t;

    typedef struct packed {
        logic a_load;
        logic a_drive;
        logic b_load;
        logic b_drive;
        logic c_load;
        logic c_drive;
        logic d_load;
        logic d_drive;
        logic pc_drive;
        logic z_drive;
        logic seq_end;
    } ctl_t;

endpackage

// File: rtl/step_ctrl_state.sv
module step_ctrl_state
    import step_ctrl_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               go_i,
    input  logic [N_INSTR-1:0] instr_i,
    output seq_st_t            st_o
);

    seq_st_t st_d, st_q;
    logic    start_ok;
    logic    at_last;

    always_comb begin
        start_ok = go_i && $onehot(instr_i);
        at_last  = st_q.busy && st_q.step[N_STEPS-1];
        st_d     = st_q;
        if (!st_q.busy) begin
            st_d.step = STEP_FIRST;
            if (start_ok) begin
                st_d.busy  = 1'b1;
                st_d.instr = instr_i;
            end
        end else if (at_last) begin
            st_d.step = STEP_FIRST;
            if (start_ok) begin
                st_d.instr = instr_i;
            end else begin
                st_d.busy = 1'b0;
            end
        end else begin
            st_d.step = {st_q.step[N_STEPS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{busy: 1'b0, step: STEP_FIRST, instr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/step_ctrl_decode.sv
module step_ctrl_decode
    import step_ctrl_pkg::*;
(
    input  seq_st_t st_i,
    output ctl_t    ctl_o
);

    logic [N_STEPS-1:0] t_d;
    logic               i1_d, i2_d, i3_d;

    always_comb begin
        t_d  = st_i.step & {N_STEPS{st_i.busy}};
        i1_d = st_i.instr[0];
        i2_d = st_i.instr[1];
        i3_d = st_i.instr[2];

        ctl_o.a_load   = (t_d[0] & i1_d) | (t_d[1] & i3_d) | (t_d[3] & i3_d) | t_d[2];
        ctl_o.a_drive  = (t_d[1] & i2_d) | (t_d[0] & i3_d);
        ctl_o.b_load   = (t_d[1] | t_d[3]) & (i1_d | i2_d);
        ctl_o.b_drive  = (t_d[0] & (i1_d | i2_d)) | (t_d[1] & i3_d);
        ctl_o.c_load   = t_d[0] & (i1_d | i2_d);
        ctl_o.c_drive  = t_d[3] & (i1_d | i2_d);
        ctl_o.d_load   = t_d[0] & (i2_d | i3_d);
        ctl_o.d_drive  = t_d[3] & i3_d;
        ctl_o.pc_drive = t_d[1] & i1_d;
        ctl_o.z_drive  = t_d[2];
        ctl_o.seq_end  = t_d[4];
    end

endmodule

// File: rtl/step_ctrl_unit.sv
module step_ctrl_unit
    import step_ctrl_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       go_i,
    input  logic [2:0] instr_i,
    output logic [4:0] step_o,
    output logic       a_load,
    output logic       a_drive,
    output logic       b_load,
    output logic       b_drive,
    output logic       c_load,
    output logic       c_drive,
    output logic       d_load,
    output logic       d_drive,
    output logic       pc_drive,
    output logic       z_drive,
    output logic       seq_end
);

    seq_st_t st_w;
    ctl_t    ctl_w;
    logic    busy_w;

    step_ctrl_state u_state (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .go_i    (go_i),
        .instr_i (instr_i),
        .st_o    (st_w)
    );

    step_ctrl_decode u_decode (
        .st_i  (st_w),
        .ctl_o (ctl_w)
    );

    assign busy_w   = st_w.busy;
    assign step_o   = st_w.step;
    assign a_load   = ctl_w.a_load;
    assign a_drive  = ctl_w.a_drive;
    assign b_load   = ctl_w.b_load;
    assign b_drive  = ctl_w.b_drive;
    assign c_load   = ctl_w.c_load;
    assign c_drive  = ctl_w.c_drive;
    assign d_load   = ctl_w.d_load;
    assign d_drive  = ctl_w.d_drive;
    assign pc_drive = ctl_w.pc_drive;
    assign z_drive  = ctl_w.z_drive;
    assign seq_end  = ctl_w.seq_end;

endmodule

// File: rtl/step_ctrl_chk.sv
module step_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       go_i,
    input logic [2:0] instr_i,
    input logic [4:0] step_o,
    input logic       busy,
    input logic       a_load,
    input logic       z_drive,
    input logic       seq_end
);

    AST_STEP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(step_o) == 1); // R3

    AST_T2_TO_T3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o[1] |=> step_o[2]); // R3

    AST_T4_TO_T5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_o[3] |=> step_o[4]); // R3

    AST_END_IN_T5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_end |-> step_o[4]); // R4

    AST_END_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_end |=> step_o[0]); // R4

    AST_BAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy && go_i && !$onehot(instr_i)) |=> !busy); // R5

    AST_T3_COMMON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && step_o[2]) |-> (z_drive && a_load)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> (!a_load && !z_drive && !seq_end)); // R1

endmodule

bind step_ctrl_unit step_ctrl_chk i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_i),
    .instr_i (instr_i),
    .step_o  (step_o),
    .busy    (busy_w),
    .a_load  (a_load),
    .z_drive (z_drive),
    .seq_end (seq_end)
);

// File: tb/test_step_ctrl_unit.sv
module test_step_ctrl_unit;

    localparam time CLK_PERIOD = 10ns;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        go_i = 1'b0;
    logic [2:0]  instr_i = '0;
    logic [4:0]  step_o;
    logic        a_load, a_drive, b_load, b_drive, c_load, c_drive;
    logic        d_load, d_drive, pc_drive, z_drive, seq_end;
    logic [10:0] ctl;

    int n_chk = 0;
    int n_bad = 0;

    step_ctrl_unit i_step_ctrl_unit (
        .clk_i, .rst_ni, .go_i, .instr_i, .step_o,
        .a_load, .a_drive, .b_load, .b_drive, .c_load, .c_drive,
        .d_load, .d_drive, .pc_drive, .z_drive, .seq_end
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    assign ctl = {a_load, a_drive, b_load, b_drive, c_load, c_drive,
                  d_load, d_drive, pc_drive, z_drive, seq_end};

    // bit order: 10 a_load 9 a_drive 8 b_load 7 b_drive 6 c_load 5 c_drive
    //            4 d_load 3 d_drive 2 pc_drive 1 z_drive 0 seq_end
    function automatic logic [10:0] exp_ctl(int ins, int st);
        logic [10:0] v = '0;
        case (st)
            0: case (ins)
                   0: begin v[10] = 1; v[7] = 1; v[6] = 1; end
                   1: begin v[6] = 1; v[7] = 1; v[4] = 1; end
                   default: begin v[4] = 1; v[9] = 1; end
               endcase
            1: case (ins)
                   0: begin v[2] = 1; v[8] = 1; end
                   1: begin v[9] = 1; v[8] = 1; end
                   default: begin v[10] = 1; v[7] = 1; end
               endcase
            2: begin v[1] = 1; v[10] = 1; end
            3: case (ins)
                   2: begin v[3] = 1; v[10] = 1; end
                   default: begin v[8] = 1; v[5] = 1; end
               endcase
            default: v[0] = 1;
        endcase
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(step_o == 5'b00001, req, 16'(step_o), 16'h1);
        check(ctl == '0, req, 16'(ctl), 16'h0);
    endtask

    // Called at a falling edge; outputs already reflect step T1 of ins.
    // nxt < 0: no new start at T5. noise: disturb inputs during T1..T4 (R6).
    task automatic walk(input int ins, input int nxt, input bit noise);
        string req;
        req = (ins == 0) ? "R7" : (ins == 1) ? "R8" : "R9";
        for (int s = 0; s < 5; s++) begin
            check(step_o == 5'(1 << s), "R3", 16'(step_o), 16'(1 << s));
            check(ctl == exp_ctl(ins, s), (s == 2) ? "R10" : req, 16'(ctl), 16'(exp_ctl(ins, s)));
            if (s < 4) begin
                go_i    = noise;
                instr_i = noise ? 3'(1 << ((ins + 1 + s) % 3)) : 3'b000;
            end else begin
                check(seq_end == 1'b1, "R4", 16'(seq_end), 16'h1);
                go_i    = (nxt >= 0);
                instr_i = (nxt >= 0) ? 3'(1 << nxt) : 3'b000;
            end
            @(negedge clk_i);
        end
        go_i    = 1'b0;
        instr_i = '0;
    endtask

    task automatic t_reset();
        check_idle("R1");
        repeat (2) @(negedge clk_i);
        check_idle("R1");
    endtask

    task automatic t_single(input int ins);
        go_i    = 1'b1;
        instr_i = 3'(1 << ins);
        @(negedge clk_i);
        go_i    = 1'b0;
        instr_i = '0;
        check(step_o == 5'b00001 && ctl == exp_ctl(ins, 0), "R2", 16'(ctl), 16'(exp_ctl(ins, 0)));
        walk(ins, -1, 1'b0);
        check_idle("R4");
    endtask

    task automatic t_bad_start();
        logic [2:0] bad [4] = '{3'b000, 3'b011, 3'b110, 3'b111};
        for (int k = 0; k < 4; k++) begin
            go_i    = 1'b1;
            instr_i = bad[k];
            @(negedge clk_i);
            go_i    = 1'b0;
            instr_i = '0;
            check_idle("R5");
            @(negedge clk_i);
            check_idle("R5");
        end
    endtask

    task automatic t_ignore_mid(input int ins);
        go_i    = 1'b1;
        instr_i = 3'(1 << ins);
        @(negedge clk_i);
        walk(ins, -1, 1'b1);
        check_idle("R6");
    endtask

    task automatic t_back_to_back();
        go_i    = 1'b1;
        instr_i = 3'b001;
        @(negedge clk_i);
        go_i    = 1'b0;
        walk(0, 1, 1'b0);
        check(ctl == exp_ctl(1, 0), "R11", 16'(ctl), 16'(exp_ctl(1, 0)));
        walk(1, 2, 1'b0);
        check(ctl == exp_ctl(2, 0), "R11", 16'(ctl), 16'(exp_ctl(2, 0)));
        walk(2, 0, 1'b0);
        walk(0, -1, 1'b0);
        check_idle("R11");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk_i);
                rst_ni = 1'b1;
                @(negedge clk_i);
                t_reset();
                t_single(0);
                t_single(1);
                t_single(2);
                t_bad_start();
                t_ignore_mid(0);
                t_ignore_mid(2);
                t_back_to_back();
            end
            begin
                repeat (5000) @(posedge clk_i);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule